// File: doc/BRIEF.md
# Register-List Stack Push Sequencer

This block stores a chosen set of registers onto a stack that grows toward lower addresses. A caller supplies a selection mask, a starting stack pointer and a mode, then pulses `start`. The sequencer walks the selection and writes one 32-bit word per clock cycle through a plain memory write port. It fetches register contents through a register-file read port whose data returns in the same cycle as the index. It keeps a working stack pointer and reports the final value with a one-cycle `done` pulse.

There are two modes. In frame mode the mask selects among the twelve upper registers, r20 to r31. After the stores, the stack pointer is lowered by a further 5-bit immediate counted in words, which reserves local space. In extended mode the mask selects among r1 to r15. One further mask bit adds the status word to the save list, and another adds an exception-context pair. The pair is the fatal-error PC and PSW when the NP flag is set and the EP flag is clear, and the normal interrupt PC and PSW in every other case.

Top module: `regpush_seq`

## Requirements
- R1: Each selected item produces exactly one 32-bit store in its own cycle. Before each store the stack pointer is lowered by 4, and the store address is the lowered pointer. Register data is taken from `rf_rdata` for the index driven on `rf_raddr` in the same cycle.
- R2: Registers are stored in ascending register number, so lower-numbered registers land at higher addresses. In extended mode the order is registers first, then the status word, then the context PC, then the context PSW.
- R3: Every store address has bits [1:0] forced to 0. The stack pointer itself keeps its low bits, so the final `sp_out` equals `sp_in` minus 4 per store, minus the frame allocation.
- R4: In frame mode (`ext_mode`=0), mask bit i (i = 0..11) selects register 20+i. Mask bits 12 to 16 have no effect. After the stores, the stack pointer is further lowered by `frame_imm`×4.
- R5: In extended mode (`ext_mode`=1), mask bit i (i = 0..14) selects register i+1, and mask bit 15 stores `status_word`. `frame_imm` has no effect in this mode.
- R6: In extended mode, mask bit 16 stores a context pair: the PC at final SP+4 and the PSW at final SP. With `np_bit`=1 and `ep_bit`=0 the pair is `fepc`/`fepsw`; otherwise it is `eipc`/`eipsw`.
- R7: An empty save list produces no store. `done` rises on the first cycle after `start` is accepted. In frame mode only the immediate adjustment is applied to the stack pointer.
- R8: With N stores, `busy` is high from the cycle after the accepted `start` until `done`. `done` is a single-cycle pulse N+1 cycles after acceptance. `sp_out` holds the final pointer on the `done` cycle, and `busy` is low on that cycle.
- R9: `start` is ignored while `busy` is high. Changes to the inputs during an operation do not alter its stores or its result, and no second operation follows.
- R10: After reset, `busy`, `done` and `mem_we` are 0 and `sp_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| ext_mode | input | 1 | 1 = extended mode, 0 = frame mode |
| sel_mask | input | 17 | Selection mask (layout per mode) |
| frame_imm | input | 5 | Frame allocation in words (frame mode) |
| sp_in | input | 32 | Starting stack pointer |
| status_word | input | 32 | Status word stored when selected |
| np_bit | input | 1 | Fatal-error-in-progress flag |
| ep_bit | input | 1 | Exception-in-progress flag |
| eipc | input | 32 | Interrupt return PC |
| eipsw | input | 32 | Interrupt saved PSW |
| fepc | input | 32 | Fatal-error return PC |
| fepsw | input | 32 | Fatal-error saved PSW |
| rf_raddr | output | 5 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (same cycle) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 32 | Working / final stack pointer |

## Verification
The bench goes after stack pointers with nonzero low bits. A design that aligned the pointer instead of only the address would finish with the wrong `sp_out`, and one that skipped alignment would emit misaligned stores. It drives all four NP/EP combinations. A swapped selection condition would store the interrupt pair where the fatal pair belongs, or swap the PC and PSW slots.

Empty masks check that no stray store appears and that frame mode still applies the immediate. Frame-mode masks with the upper bits set would show as extra stores if those bits leaked through. A `start` pulsed in mid-operation would show up as corrupted stores or a second run. Random masks compare every address and data word in order, so a reversed priority shows at once as r15 or r31 landing highest.

// File: rtl/regpush_pkg.sv
package regpush_pkg;
  localparam int EXT_GPRS     = 15;
  localparam int FRAME_GPRS   = 12;
  localparam int EXT_BASE     = 1;
  localparam int FRAME_BASE   = 20;
  localparam int SLOT_STATUS  = EXT_GPRS;
  localparam int SLOT_CTX_PC  = EXT_GPRS + 1;
  localparam int SLOT_CTX_PSW = EXT_GPRS + 2;
  localparam int NUM_SLOTS    = EXT_GPRS + 3;
  localparam int SLOT_W       = $clog2(NUM_SLOTS);
  localparam int MASK_W       = EXT_GPRS + 2;

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;
endpackage

// File: rtl/regpush_mask_expand.sv
module regpush_mask_expand
  import regpush_pkg::*;
(
  input  logic                 ext_mode,
  input  logic [MASK_W-1:0]    mask,
  output logic [NUM_SLOTS-1:0] slots
);
  // register slots: frame mode uses only the low FRAME_GPRS bits
  for (genvar g = 0; g < EXT_GPRS; g++) begin : g_gpr
    if (g < FRAME_GPRS) begin : g_shared
      assign slots[g] = mask[g];
    end else begin : g_ext_only
      assign slots[g] = ext_mode & mask[g];
    end
  end

  assign slots[SLOT_STATUS]  = ext_mode & mask[EXT_GPRS];
  assign slots[SLOT_CTX_PC]  = ext_mode & mask[EXT_GPRS+1];
  assign slots[SLOT_CTX_PSW] = ext_mode & mask[EXT_GPRS+1];
endmodule

// File: rtl/regpush_slot_pick.sv
module regpush_slot_pick #(
  parameter int N  = 18,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  // lowest pending slot wins
  always_comb begin
    any    = |pend;
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
    if (any) onehot[idx] = 1'b1;
  end
endmodule

// File: rtl/regpush_word_sel.sv
module regpush_word_sel
  import regpush_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RIDX_W = 5
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic              ext_mode,
  input  logic [DATA_W-1:0] rf_rdata,
  input  logic [DATA_W-1:0] status_w,
  input  logic [DATA_W-1:0] ctx_pc,
  input  logic [DATA_W-1:0] ctx_psw,
  output logic [RIDX_W-1:0] rf_raddr,
  output logic [DATA_W-1:0] word
);
  always_comb begin
    rf_raddr = (ext_mode ? RIDX_W'(EXT_BASE) : RIDX_W'(FRAME_BASE)) + RIDX_W'(slot);
    if (slot == SLOT_W'(SLOT_STATUS))       word = status_w;
    else if (slot == SLOT_W'(SLOT_CTX_PC))  word = ctx_pc;
    else if (slot == SLOT_W'(SLOT_CTX_PSW)) word = ctx_psw;
    else                                    word = rf_rdata;
  end
endmodule

// File: rtl/regpush_seq.sv
module regpush_seq
  import regpush_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RIDX_W = 5,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ext_mode,
  input  logic [MASK_W-1:0] sel_mask,
  input  logic [IMM_W-1:0]  frame_imm,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] status_word,
  input  logic              np_bit,
  input  logic              ep_bit,
  input  logic [DATA_W-1:0] eipc,
  input  logic [DATA_W-1:0] eipsw,
  input  logic [DATA_W-1:0] fepc,
  input  logic [DATA_W-1:0] fepsw,
  output logic [RIDX_W-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] sp_out
);
  localparam int WORD_B = DATA_W / 8;
  localparam int ALIGN  = $clog2(WORD_B);

  seq_state_e           state_q;
  logic [NUM_SLOTS-1:0] pend_q, start_slots, pick_oh;
  logic                 pick_any;
  logic [SLOT_W-1:0]    pick_idx;
  logic                 ext_q;
  logic [IMM_W-1:0]     imm_q;
  logic [DATA_W-1:0]    sp_q, status_q, ctx_pc_q, ctx_psw_q;
  logic [DATA_W-1:0]    sp_dec, st_addr, frame_adj, word;
  logic                 fatal_ctx;

  regpush_mask_expand u_expand (
    .ext_mode (ext_mode),
    .mask     (sel_mask),
    .slots    (start_slots)
  );

  regpush_slot_pick #(.N(NUM_SLOTS), .IW(SLOT_W)) u_pick (
    .pend   (pend_q),
    .any    (pick_any),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  regpush_word_sel #(.DATA_W(DATA_W), .RIDX_W(RIDX_W)) u_sel (
    .slot     (pick_idx),
    .ext_mode (ext_q),
    .rf_rdata (rf_rdata),
    .status_w (status_q),
    .ctx_pc   (ctx_pc_q),
    .ctx_psw  (ctx_psw_q),
    .rf_raddr (rf_raddr),
    .word     (word)
  );

  assign fatal_ctx = np_bit & ~ep_bit;
  assign sp_dec    = sp_q - DATA_W'(WORD_B);
  assign st_addr   = sp_dec & ~DATA_W'(WORD_B - 1);
  assign frame_adj = ext_q ? '0 : (DATA_W'(imm_q) << ALIGN);
  assign sp_out    = sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_IDLE;
      pend_q    <= '0;
      ext_q     <= 1'b0;
      imm_q     <= '0;
      sp_q      <= '0;
      status_q  <= '0;
      ctx_pc_q  <= '0;
      ctx_psw_q <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      done   <= 1'b0;
      mem_we <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            pend_q    <= start_slots;
            ext_q     <= ext_mode;
            imm_q     <= frame_imm;
            sp_q      <= sp_in;
            status_q  <= status_word;
            ctx_pc_q  <= fatal_ctx ? fepc  : eipc;
            ctx_psw_q <= fatal_ctx ? fepsw : eipsw;
            busy      <= 1'b1;
            state_q   <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (pick_any) begin
            pend_q    <= pend_q & ~pick_oh;
            sp_q      <= sp_dec;
            mem_we    <= 1'b1;
            mem_addr  <= st_addr;
            mem_wdata <= word;
          end else begin
            sp_q    <= sp_q - frame_adj;
            done    <= 1'b1;
            busy    <= 1'b0;
            state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regpush_seq_chk.sv
module regpush_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] sp_out
);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !done) |-> busy);

  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_write_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[1:0] == 2'b00));

  assert_addr_tracks_sp_R1: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[DATA_W-1:2] == sp_out[DATA_W-1:2]));

  assert_addr_descends_R1: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - DATA_W'(4)));
endmodule

bind regpush_seq regpush_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .sp_out   (sp_out)
);

// File: tb/regpush_seq_tb_top.sv
module regpush_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        ext_mode;
  logic [16:0] sel_mask;
  logic [4:0]  frame_imm;
  logic [31:0] sp_in, status_word, eipc, eipsw, fepc, fepsw;
  logic        np_bit, ep_bit;
  logic [4:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        busy, done;
  logic [31:0] sp_out;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  function automatic logic [31:0] rf_val(input logic [4:0] r);
    return 32'h1357_0000 + ({27'd0, r} * 32'h0000_0111);
  endfunction
  assign rf_rdata = rf_val(rf_raddr);

  regpush_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .ext_mode(ext_mode),
    .sel_mask(sel_mask), .frame_imm(frame_imm), .sp_in(sp_in),
    .status_word(status_word), .np_bit(np_bit), .ep_bit(ep_bit),
    .eipc(eipc), .eipsw(eipsw), .fepc(fepc), .fepsw(fepsw),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .sp_out(sp_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compare every store against the scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (!rst && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected store addr", mem_addr, 32'h0);
      end else begin
        e = exp_q.pop_front();
        chk(mem_addr == e.a, e.req, "store addr", mem_addr, e.a);
        chk(mem_wdata == e.d, e.req, "store data", mem_wdata, e.d);
      end
    end
  end

  task automatic push_exp(inout logic [31:0] sp, input logic [31:0] d, input string req);
    exp_t e;
    sp = sp - 32'd4;
    e.a = sp & ~32'd3;
    e.d = d;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic run_op(input bit ext, input logic [16:0] mask, input logic [4:0] imm,
                        input logic [31:0] sp0, input bit np, input bit ep,
                        input bit interfere, input string req);
    logic [31:0] sp, st, cpc, cps;
    int n = 0;
    int cyc = 0;
    st  = $urandom;
    cpc = (np && !ep) ? 32'hFEC0_0000 + $urandom%256 : 32'hE1C0_0000 + $urandom%256;
    cps = (np && !ep) ? 32'hFE50_0000 + $urandom%256 : 32'hE150_0000 + $urandom%256;
    sp  = sp0;
    if (ext) begin
      for (int i = 0; i < 15; i++)
        if (mask[i]) begin push_exp(sp, rf_val(5'(i + 1)), req); n++; end
      if (mask[15]) begin push_exp(sp, st, req); n++; end
      if (mask[16]) begin
        push_exp(sp, cpc, req); push_exp(sp, cps, req); n += 2;
      end
    end else begin
      for (int i = 0; i < 12; i++)
        if (mask[i]) begin push_exp(sp, rf_val(5'(i + 20)), req); n++; end
      sp = sp - {25'd0, imm, 2'b00};
    end
    @(negedge clk);
    ext_mode = ext; sel_mask = mask; frame_imm = imm; sp_in = sp0;
    np_bit = np; ep_bit = ep; status_word = st;
    eipc  = (np && !ep) ? 32'hDEAD_0001 : cpc;
    eipsw = (np && !ep) ? 32'hDEAD_0002 : cps;
    fepc  = (np && !ep) ? cpc : 32'hDEAD_0003;
    fepsw = (np && !ep) ? cps : 32'hDEAD_0004;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (done || cyc > 100) break;
      if (interfere && cyc == 1) begin
        start = 1'b1; sel_mask = '1; ext_mode = ~ext; sp_in = $urandom;
        status_word = $urandom; eipc = $urandom; fepc = $urandom;
      end
    end
    chk(done && cyc == n + 1, "R8", "done cycle", 32'(cyc), 32'(n + 1));
    chk(!busy, "R8", "busy low at done", {31'd0, busy}, 32'd0);
    chk(sp_out == sp, req, "final sp", sp_out, sp);
    chk(exp_q.size() == 0, req, "stores missing", 32'(exp_q.size()), 32'd0);
    @(negedge clk);
    chk(!done && !busy, "R8", "done one pulse", {30'd0, done, busy}, 32'd0);
    if (interfere) begin
      repeat (3) @(negedge clk);
      chk(!busy && sp_out == sp, "R9", "no second run", sp_out, sp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; ext_mode = 1'b0; sel_mask = '0; frame_imm = '0;
    sp_in = '0; status_word = '0; np_bit = 1'b0; ep_bit = 1'b0;
    eipc = '0; eipsw = '0; fepc = '0; fepsw = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy && !done && !mem_we && sp_out == 0, "R10", "reset outputs",
        {29'd0, busy, done, mem_we} | sp_out, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    // R5: ends of the extended register range
    run_op(1'b1, 17'h04001, 5'd9, 32'h0000_2000, 1'b0, 1'b0, 1'b0, "R5");
    // R4: full frame list plus allocation
    run_op(1'b0, 17'h00FFF, 5'd5, 32'h0000_3000, 1'b0, 1'b0, 1'b0, "R4");
    // R4: upper mask bits ignored in frame mode
    run_op(1'b0, 17'h1F081, 5'd31, 32'h0000_4000, 1'b1, 1'b0, 1'b0, "R4");
    // R5 and R2: registers then status word
    run_op(1'b1, 17'h0A00A, 5'd3, 32'h0000_5000, 1'b0, 1'b0, 1'b0, "R2");
    // R6: all NP/EP combinations
    run_op(1'b1, 17'h10000, 5'd0, 32'h0000_6000, 1'b1, 1'b0, 1'b0, "R6");
    run_op(1'b1, 17'h10000, 5'd0, 32'h0000_6100, 1'b1, 1'b1, 1'b0, "R6");
    run_op(1'b1, 17'h18001, 5'd0, 32'h0000_6200, 1'b0, 1'b0, 1'b0, "R6");
    run_op(1'b1, 17'h10002, 5'd0, 32'h0000_6300, 1'b0, 1'b1, 1'b0, "R6");
    // R7: empty lists
    run_op(1'b1, 17'h00000, 5'd7, 32'h0000_7000, 1'b0, 1'b0, 1'b0, "R7");
    run_op(1'b0, 17'h00000, 5'd7, 32'h0000_7000, 1'b0, 1'b0, 1'b0, "R7");
    // R3: unaligned stack pointer
    run_op(1'b1, 17'h1C003, 5'd0, 32'h0000_1003, 1'b1, 1'b0, 1'b0, "R3");
    run_op(1'b0, 17'h00805, 5'd2, 32'h0000_1006, 1'b0, 1'b0, 1'b0, "R3");
    // R9: start pulsed mid-operation
    run_op(1'b1, 17'h00070, 5'd0, 32'h0000_8000, 1'b0, 1'b0, 1'b1, "R9");
    run_op(1'b0, 17'h00003, 5'd4, 32'h0000_8800, 1'b0, 1'b0, 1'b1, "R9");
    // R2 and R1: random lists
    for (int k = 0; k < 40; k++) begin
      run_op(1'($urandom), 17'($urandom), 5'($urandom), $urandom,
             1'($urandom), 1'($urandom), 1'b0, "R2");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule